// File: doc/BRIEF.md
# Multiplier-free symmetric FIR filter

This block is a linear-phase, ten-tap FIR filter for a stream of signed samples. It builds each output without a single multiplier. A tapped delay line holds the last ten samples. The two samples at each mirrored pair of positions are added together, which gives five pre-sums that share five coefficients.

Every bit position of the pre-sums takes one bit from each of the five pre-sums. Those five bits address a 32-entry table of precomputed coefficient sums. The thirteen table results are weighted by their bit position, with the sign bit's result subtracted, and a pipelined adder tree adds them into the full-precision output.

A sample is offered with `in_valid`, and exactly one result appears per accepted sample. If `in_valid` is sampled high at clock edge k, the matching `out_data` and `out_valid` are registered at edge k+6. The coefficients are parameters, and the tables are computed from them at elaboration.

Top module: `da_fir`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` is low. Reset empties the delay line, so the first result after reset equals c0 times the first sample, with c0 the outermost coefficient (c0 = -7 by default).
- R2: Each sample accepted at edge k gives exactly one `out_valid` pulse, with its result registered at edge k+6. `out_valid` is never high without a matching accepted sample.
- R3: `out_data` equals the sum over k = 0..9 of h[k]*x(n-k), where x(n) is the newest accepted sample. The response is symmetric, h[k] = h[9-k] = c[k] for k < 5, and the defaults are c = {-7, -25, 40, 150, 255}.
- R4: `in_sample` is 12-bit two's complement. `out_data` is 26-bit two's complement and full precision, with no rounding or saturation. A run of +2047 gives 2047*2*413, and a run of -2048 gives -2048*2*413.
- R5: The delay line moves only on cycles where `in_valid` is high. Idle cycles between samples leave every later result unchanged compared with the same samples sent back to back.
- R6: A single sample of amplitude A followed by zeros produces the ten results A*c0, A*c1, ..., A*c4, A*c4, ..., A*c0 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | 12 | Signed input sample |
| out_valid | output | 1 | `out_data` holds a new result |
| out_data | output | 26 | Signed full-precision filter result |

## Verification
Suppose one coefficient-sum table entry is wrong. The error then shows only for samples whose pre-sum bit pattern selects that entry, so the stream tests use many different samples and signs. A wrong sign-bit weight shows as soon as any negative sample passes through, which makes the all-negative run and the alternating extreme run sensitive to it. A delay-line fault or a pairing fault shows up in the impulse response within ten results of the impulse, and a valid-pipeline fault shows at the very next output, as a missing, extra or late pulse.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // Number of binary levels needed to reduce n leaves to one node.
    function automatic int unsigned tree_depth(int unsigned n);
        int unsigned d;
        d = 0;
        while ((32'd1 << d) < n) d++;
        return d;
    endfunction

    // Width needed for a signed sum of n values, each w bits wide.
    function automatic int unsigned sum_width(int unsigned w, int unsigned n);
        return w + tree_depth(n);
    endfunction

endpackage

// File: rtl/da_fir_preadd.sv
// Ten-stage delay line followed by a registered pre-add of mirrored taps.
module da_fir_preadd #(
    parameter int DATA_W = 12,
    parameter int NPAIR  = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  in_valid,
    input  logic [DATA_W-1:0]                     in_sample,
    output logic                                  out_valid,
    output logic [NPAIR-1:0][DATA_W:0]            out_sums
);
    localparam int NTAPS = 2 * NPAIR;
    localparam int PRE_W = DATA_W + 1;

    typedef struct packed {
        logic [NTAPS-1:0][DATA_W-1:0] taps;
        logic [NPAIR-1:0][PRE_W-1:0]  sums;
        logic                         v_tap;
        logic                         v_sum;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.v_tap = in_valid;
        st_d.v_sum = st_q.v_tap;
        if (in_valid) begin
            st_d.taps[0] = in_sample;
            for (int j = 1; j < NTAPS; j++) begin
                st_d.taps[j] = st_q.taps[j-1];
            end
        end
        for (int i = 0; i < NPAIR; i++) begin
            st_d.sums[i] = {st_q.taps[i][DATA_W-1], st_q.taps[i]}
                         + {st_q.taps[NTAPS-1-i][DATA_W-1], st_q.taps[NTAPS-1-i]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.v_sum;
    assign out_sums  = st_q.sums;

endmodule

// File: rtl/da_fir_slice.sv
// One bit slice: a coefficient-sum table, with the result weighted by bit position.
module da_fir_slice #(
    parameter int                      NPAIR  = 5,
    parameter int                      COEF_W = 10,
    parameter int                      SUM_W  = 13,
    parameter int                      OUT_W  = 26,
    parameter int                      SLICE  = 0,
    parameter bit                      NEG    = 1'b0,
    parameter logic [NPAIR*COEF_W-1:0] COEFS  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPAIR-1:0] addr,
    output logic [OUT_W-1:0] term
);
    localparam int ROM_N = 1 << NPAIR;

    function automatic logic [ROM_N*SUM_W-1:0] build_rom();
        logic [ROM_N*SUM_W-1:0] r;
        r = '0;
        for (int a = 0; a < ROM_N; a++) begin
            logic signed [SUM_W-1:0]  s;
            logic signed [COEF_W-1:0] c;
            s = '0;
            for (int i = 0; i < NPAIR; i++) begin
                c = COEFS[i*COEF_W +: COEF_W];
                if (((a >> i) & 1) == 1) s = s + SUM_W'(c);
            end
            r[a*SUM_W +: SUM_W] = s;
        end
        return r;
    endfunction

    localparam logic [ROM_N*SUM_W-1:0] ROM = build_rom();

    typedef struct packed {
        logic [OUT_W-1:0] term;
    } state_t;

    state_t st_d, st_q;

    logic signed [SUM_W-1:0] entry;
    logic        [OUT_W-1:0] weighted;

    always_comb begin
        st_d     = st_q;
        entry    = ROM[addr*SUM_W +: SUM_W];
        weighted = OUT_W'(entry) << SLICE;
        if (NEG) st_d.term = -weighted;
        else     st_d.term = weighted;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign term = st_q.term;

endmodule

// File: rtl/da_fir_tree.sv
// Balanced, fully registered adder tree. Leaves are padded with zeros up to a power of two.
module da_fir_tree #(
    parameter int NLEAF = 13,
    parameter int W     = 26
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [NLEAF-1:0][W-1:0]   leaves,
    output logic                      out_valid,
    output logic [W-1:0]              out_sum
);
    import da_fir_pkg::*;

    localparam int LVL  = (tree_depth(NLEAF) < 1) ? 1 : tree_depth(NLEAF);
    localparam int NPAD = 1 << LVL;
    localparam int NINT = NPAD - 1;

    typedef struct packed {
        logic [NINT-1:0][W-1:0] node;
        logic [LVL-1:0]         vld;
    } state_t;

    state_t st_d, st_q;

    logic [NPAD-1:0][W-1:0] pad;
    logic [W-1:0]           lhs, rhs;

    always_comb begin
        pad = '0;
        for (int j = 0; j < NLEAF; j++) pad[j] = leaves[j];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = (st_q.vld << 1) | LVL'(in_valid);
        lhs      = '0;
        rhs      = '0;
        for (int k = 0; k < NINT; k++) begin
            if (2*k + 1 >= NINT) lhs = pad[2*k + 1 - NINT];
            else                 lhs = st_q.node[2*k + 1];
            if (2*k + 2 >= NINT) rhs = pad[2*k + 2 - NINT];
            else                 rhs = st_q.node[2*k + 2];
            st_d.node[k] = lhs + rhs;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld[LVL-1];
    assign out_sum   = st_q.node[0];

endmodule

// File: rtl/da_fir.sv
// Symmetric ten-tap FIR filter built from coefficient-sum tables.
module da_fir #(
    parameter int                      DATA_W = 12,
    parameter int                      NPAIR  = 5,
    parameter int                      COEF_W = 10,
    parameter logic [NPAIR*COEF_W-1:0] COEFS  = {10'h0FF, 10'h096, 10'h028, 10'h3E7, 10'h3F9}
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           in_valid,
    input  logic [DATA_W-1:0]                              in_sample,
    output logic                                           out_valid,
    output logic [DATA_W+1+da_fir_pkg::sum_width(COEF_W, NPAIR)-1:0] out_data
);
    import da_fir_pkg::*;

    localparam int PRE_W = DATA_W + 1;
    localparam int SUM_W = sum_width(COEF_W, NPAIR);
    localparam int OUT_W = PRE_W + SUM_W;

    typedef struct packed {
        logic v_term;
    } state_t;

    state_t st_d, st_q;

    logic                         pre_valid;
    logic [NPAIR-1:0][PRE_W-1:0]  pre_sums;
    logic [PRE_W-1:0][OUT_W-1:0]  terms;

    da_fir_preadd #(
        .DATA_W (DATA_W),
        .NPAIR  (NPAIR)
    ) u_preadd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (pre_valid),
        .out_sums  (pre_sums)
    );

    for (genvar b = 0; b < PRE_W; b++) begin : g_slice
        logic [NPAIR-1:0] addr;
        always_comb begin
            for (int i = 0; i < NPAIR; i++) addr[i] = pre_sums[i][b];
        end
        da_fir_slice #(
            .NPAIR  (NPAIR),
            .COEF_W (COEF_W),
            .SUM_W  (SUM_W),
            .OUT_W  (OUT_W),
            .SLICE  (b),
            .NEG    (b == PRE_W - 1),
            .COEFS  (COEFS)
        ) u_slice (
            .clk  (clk),
            .rst  (rst),
            .addr (addr),
            .term (terms[b])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.v_term = pre_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    da_fir_tree #(
        .NLEAF (PRE_W),
        .W     (OUT_W)
    ) u_tree (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (st_q.v_term),
        .leaves    (terms),
        .out_valid (out_valid),
        .out_sum   (out_data)
    );

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
    parameter int PW = 65
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [PW-1:0] presum
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);

    // R2
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 7));

    // R2
    valid_delivery_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##6 out_valid);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 $stable(presum));
endmodule

bind da_fir da_fir_chk #(.PW(NPAIR*PRE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .presum    (pre_sums)
);

// File: tb/tb_da_fir.sv
`timescale 1ns/1ps
module tb_da_fir;
    localparam int OUT_W = 26;
    localparam int LAT   = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [11:0]       in_sample = '0;
    logic              out_valid;
    logic [OUT_W-1:0]  out_data;

    always #2 clk = ~clk;

    da_fir dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        int    val;
        int    cyc;
        string req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    int    hist[10];
    int    coef[5] = '{-7, -25, 40, 150, 255};
    int    seed   = 7;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int h_of(int k);
        return (k < 5) ? coef[k] : coef[9 - k];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 10; k++) hist[k] = 0;
    endtask

    task automatic send(int x, string req);
        item_t it;
        int    y;
        @(posedge clk);
        #1;
        in_valid  = 1'b1;
        in_sample = x[11:0];
        for (int k = 9; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = x;
        y = 0;
        for (int k = 0; k < 10; k++) y += h_of(k) * hist[k];
        it.val = y;
        it.cyc = cyc + LAT;
        it.req = req;
        q.push_back(it);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_burst(int n, int x, string req);
        for (int i = 0; i < n; i++) send(x, req);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // The monitor pops the expected result and compares value and arrival cycle.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                item_t it;
                int    act;
                it  = q.pop_front();
                act = int'($signed(out_data));
                check(act == it.val, it.req, "out_data", act, it.val);
                check(cyc == it.cyc, "R2", "latency", cyc, it.cyc);
            end
        end
    end

    // Back-to-back driver that keeps in_valid high across samples.
    task automatic stream(int n, string req);
        item_t it;
        int    x;
        int    y;
        @(posedge clk);
        #1;
        for (int i = 0; i < n; i++) begin
            seed = seed * 1103515245 + 12345;
            x = int'((seed >>> 8) & 32'hFFF) - 2048;
            in_valid  = 1'b1;
            in_sample = x[11:0];
            for (int k = 9; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = x;
            y = 0;
            for (int k = 0; k < 10; k++) y += h_of(k) * hist[k];
            it.val = y;
            it.cyc = cyc + LAT;
            it.req = req;
            q.push_back(it);
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        idle(2);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R1: the first output after reset sees an empty delay line.
        send(300, "R1");
        // R6: impulse response.
        send(1000, "R6");
        for (int i = 0; i < 9; i++) send(0, "R6");
        idle(12);

        // R3: back-to-back pseudo-random stream.
        stream(40, "R3");
        idle(12);

        // R5: the same kind of stream with gaps between samples.
        for (int i = 0; i < 20; i++) begin
            seed = seed * 1103515245 + 12345;
            send(int'((seed >>> 8) & 32'hFFF) - 2048, "R5");
            idle(i % 4);
        end
        idle(12);

        // R4: extremes, without saturation.
        send_burst(12, 2047, "R4");
        send_burst(12, -2048, "R4");
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 2047 : -2048, "R4");
        idle(12);
        check(q.size() == 0, "R2", "pending results", q.size(), 0);

        // R1: a mid-run reset clears the delay line.
        send_burst(5, 1234, "R3");
        idle(12);
        rst = 1'b1;
        idle(2);
        check(out_valid == 1'b0, "R1", "out_valid in mid-run reset", int'(out_valid), 0);
        rst = 1'b0;
        clear_model();
        idle(1);
        send(-1500, "R1");
        send(2, "R1");
        idle(12);
        check(q.size() == 0, "R2", "pending results at end", q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule